// File: doc/BRIEF.md
# Logic Analyzer Trigger Matcher

This block watches a stream of 16-channel logic samples and raises a trigger when the stream meets a programmed condition. Each cycle in which the sample strobe is high brings in one new sample. The block keeps the previous accepted sample so that it can detect transitions between consecutive samples.

There are two modes. In normal mode, a masked state comparison is ANDed with a transition term. That term is the OR of up to two edge detectors, and each detector watches one chosen channel for a chosen polarity. In fast mode, the block ignores all of that and watches one pin named by a select byte for one edge.

Software arms the matcher with a single-cycle strobe. The first match after arming produces a one-cycle pulse. A sticky flag then stays set and blocks further pulses until the next arm.

Top module: `la_trigger_matcher`

## Requirements
- R1: After reset, `trig_o` and `fired_o` are 0, the previous-sample register holds zero, and no trigger fires until the first `arm_i` strobe.
- R2: In normal mode with no edge detector enabled, a valid sample matches when `(smp_data_i & state_mask_i) == (state_value_i & state_mask_i)`. Value bits outside the mask have no effect, and an all-zero mask matches every sample.
- R3: Edge detector k uses channel `edge_ch_i[4k+3:4k]` and polarity `edge_fall_i[k]`. Polarity 0 needs the previous bit at 0 and the current bit at 1. Polarity 1 needs the previous bit at 1 and the current bit at 0. A detector fires only while `edge_en_i[k]` is 1.
- R4: In normal mode with at least one edge detector enabled, the enabled detectors are ORed into a transition term. A match needs both the transition term and the state condition of R2 on the same sample.
- R5: The first valid sample after an arm never produces an edge match, in either mode.
- R6: In fast mode (`fast_mode_i`=1), the only condition is one edge on the channel numbered by `fast_sel_i[2:0]` (channels 0 to 7). `fast_sel_i[3]`=1 selects a falling edge and 0 selects a rising edge. The mask, the value, the edge-detector settings and `fast_sel_i[7:4]` have no effect.
- R7: A match on a sample presented before clock edge N sets `trig_o` high for exactly the cycle after edge N, and sets `fired_o` at that same edge. `fired_o` then stays at 1, and later matches give no further pulse, until the next arm.
- R8: `arm_i` clears `fired_o` and discards the sample offered in the same cycle. A cycle with `smp_valid_i` low neither matches nor updates the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Single-cycle arm strobe |
| fast_mode_i | input | 1 | 1 = single-pin fast mode, 0 = normal mode |
| state_mask_i | input | 16 | Channels taking part in the state condition |
| state_value_i | input | 16 | Required levels of the masked channels |
| edge_en_i | input | 2 | Enable for each edge detector |
| edge_ch_i | input | 8 | Channel index, 4 bits per detector |
| edge_fall_i | input | 2 | Polarity per detector, 1 = falling |
| fast_sel_i | input | 8 | Fast-mode select: [2:0] pin, [3] falling |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 16 | Sample, one bit per channel |
| trig_o | output | 1 | One-cycle trigger pulse |
| fired_o | output | 1 | Sticky fired status |

## Verification
The bench builds the block with its defaults: 16 channels, two edge detectors and the fast path present. This configuration reaches both modes, the OR of two detectors, and the full 3-bit fast pin range, including pin 7. It also lets a channel above 7 toggle in fast mode to show that it is ignored. Random configurations with sparse masks cover state-only, edge-only and combined conditions. Directed cases cover the first sample after an arm, arming in the same cycle as a sample, and strobe-low cycles.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;
   localparam int unsigned SEL_BYTE_W   = 8;
   localparam int unsigned FAST_PIN_W   = 3;
   localparam int unsigned FAST_POL_BIT = 3;

   typedef enum logic {
      POL_RISE = 1'b0,
      POL_FALL = 1'b1
   } edge_pol_e;

   // transition test between two consecutive levels of one channel
   function automatic logic edge_seen(logic prev_b, logic cur_b, edge_pol_e pol);
      return (pol == POL_FALL) ? (prev_b & ~cur_b) : (~prev_b & cur_b);
   endfunction
endpackage

// File: rtl/trig_state_cmp.sv
module trig_state_cmp #(
   parameter int unsigned CH_W = 16
) (
   input  logic [CH_W-1:0] data_i,
   input  logic [CH_W-1:0] mask_i,
   input  logic [CH_W-1:0] value_i,
   output logic            hit_o
);
   logic [CH_W-1:0] diff;

   assign diff  = (data_i ^ value_i) & mask_i;
   assign hit_o = (diff == '0);

   always_comb begin
      if (hit_o) begin
         assert_masked_equal_R2: assert ((data_i & mask_i) == (value_i & mask_i));
      end
   end
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
   import la_trig_pkg::*;
#(
   parameter int unsigned CH_W  = 16,
   parameter int unsigned IDX_W = $clog2(CH_W)
) (
   input  logic             enable_i,
   input  logic [IDX_W-1:0] ch_i,
   input  logic             fall_i,
   input  logic             prev_ok_i,
   input  logic [CH_W-1:0]  prev_i,
   input  logic [CH_W-1:0]  cur_i,
   output logic             hit_o
);
   logic prev_b, cur_b;

   assign prev_b = prev_i[ch_i];
   assign cur_b  = cur_i[ch_i];
   assign hit_o  = enable_i & prev_ok_i & edge_seen(prev_b, cur_b, edge_pol_e'(fall_i));

   always_comb begin
      if (hit_o) begin
         assert_edge_toggled_R3: assert (prev_b != cur_b && cur_b == !fall_i);
      end
   end
endmodule

// File: rtl/trig_fast_pin.sv
module trig_fast_pin
   import la_trig_pkg::*;
#(
   parameter int unsigned CH_W = 16
) (
   input  logic [FAST_PIN_W:0] sel_i,
   input  logic                prev_ok_i,
   input  logic [CH_W-1:0]     prev_i,
   input  logic [CH_W-1:0]     cur_i,
   output logic                hit_o
);
   localparam int unsigned PINS = 1 << FAST_PIN_W;

   logic [FAST_PIN_W-1:0] pin;
   logic [PINS-1:0]       prev_lo, cur_lo;

   assign pin     = sel_i[FAST_PIN_W-1:0];
   assign prev_lo = prev_i[PINS-1:0];
   assign cur_lo  = cur_i[PINS-1:0];
   assign hit_o   = prev_ok_i &
                    edge_seen(prev_lo[pin], cur_lo[pin], edge_pol_e'(sel_i[FAST_POL_BIT]));

   always_comb begin
      if (hit_o) begin
         assert_fast_pin_toggled_R6: assert (prev_lo[pin] != cur_lo[pin]);
      end
   end
endmodule

// File: rtl/la_trigger_matcher.sv
module la_trigger_matcher
   import la_trig_pkg::*;
#(
   parameter int unsigned CH_W     = 16,
   parameter int unsigned NUM_EDGE = 2,
   parameter bit          FAST_EN  = 1'b1
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 arm_i,
   input  logic                                 fast_mode_i,
   input  logic [CH_W-1:0]                      state_mask_i,
   input  logic [CH_W-1:0]                      state_value_i,
   input  logic [NUM_EDGE-1:0]                  edge_en_i,
   input  logic [NUM_EDGE*$clog2(CH_W)-1:0]     edge_ch_i,
   input  logic [NUM_EDGE-1:0]                  edge_fall_i,
   input  logic [SEL_BYTE_W-1:0]                fast_sel_i,
   input  logic                                 smp_valid_i,
   input  logic [CH_W-1:0]                      smp_data_i,
   output logic                                 trig_o,
   output logic                                 fired_o
);
   localparam int unsigned IDX_W = $clog2(CH_W);

   // elaboration-time parameter checks
   if (CH_W < 2) begin : g_chk_ch
      $error("CH_W must be at least 2");
   end
   if (NUM_EDGE < 1) begin : g_chk_edge
      $error("NUM_EDGE must be at least 1");
   end
   if (FAST_EN && CH_W < (1 << FAST_PIN_W)) begin : g_chk_fast
      $error("fast mode needs CH_W >= 8");
   end

   logic [CH_W-1:0]     prev_q;
   logic                prev_ok_q, armed_q, fired_q, trig_q;
   logic                state_hit, fast_hit, normal_hit, mode_hit, fire;
   logic [NUM_EDGE-1:0] edge_hit;

   trig_state_cmp #(.CH_W(CH_W)) u_state (
      .data_i (smp_data_i),
      .mask_i (state_mask_i),
      .value_i(state_value_i),
      .hit_o  (state_hit)
   );

   for (genvar k = 0; k < NUM_EDGE; k++) begin : g_edge
      trig_edge_det #(.CH_W(CH_W), .IDX_W(IDX_W)) u_det (
         .enable_i (edge_en_i[k]),
         .ch_i     (edge_ch_i[k*IDX_W +: IDX_W]),
         .fall_i   (edge_fall_i[k]),
         .prev_ok_i(prev_ok_q),
         .prev_i   (prev_q),
         .cur_i    (smp_data_i),
         .hit_o    (edge_hit[k])
      );
   end

   // no enabled detector: the state condition decides alone
   assign normal_hit = state_hit & ((edge_en_i == '0) | (|edge_hit));

   if (FAST_EN) begin : g_fast
      logic unused_sel_hi;
      assign unused_sel_hi = ^fast_sel_i[SEL_BYTE_W-1:FAST_PIN_W+1];
      trig_fast_pin #(.CH_W(CH_W)) u_fast (
         .sel_i    (fast_sel_i[FAST_PIN_W:0]),
         .prev_ok_i(prev_ok_q),
         .prev_i   (prev_q),
         .cur_i    (smp_data_i),
         .hit_o    (fast_hit)
      );
      assign mode_hit = fast_mode_i ? fast_hit : normal_hit;
   end else begin : g_nofast
      logic unused_fast;
      assign unused_fast = fast_mode_i ^ (^fast_sel_i);
      assign fast_hit    = 1'b0;
      assign mode_hit    = normal_hit;
   end

   assign fire = smp_valid_i & ~arm_i & armed_q & ~fired_q & mode_hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
         armed_q   <= 1'b0;
         fired_q   <= 1'b0;
         trig_q    <= 1'b0;
      end else begin
         trig_q <= fire;
         if (arm_i) begin
            armed_q   <= 1'b1;
            fired_q   <= 1'b0;
            prev_ok_q <= 1'b0;
         end else begin
            if (fire) fired_q <= 1'b1;
            if (smp_valid_i) begin
               prev_q    <= smp_data_i;
               prev_ok_q <= 1'b1;
            end
         end
      end
   end

   assign trig_o  = trig_q;
   assign fired_o = fired_q;

   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_q |=> !trig_o);
   assert_no_history_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!prev_ok_q && (fast_mode_i || edge_en_i != '0)) |=> !trig_o);
   assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |=> !trig_o);
   assert_sticky_fired_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fired_o && !arm_i) |=> fired_o);
   assert_first_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> (fired_o && !$past(fired_o)));
   assert_arm_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> (!fired_o && !trig_o));
   assert_strobe_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_valid_i |=> !trig_o);
endmodule

// File: tb/tb_la_trigger_matcher.sv
module tb_la_trigger_matcher;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0, fmode = 1'b0, sv = 1'b0;
   logic [15:0] mask = '0, value = '0, sd = '0;
   logic [1:0]  en = '0, fall = '0;
   logic [7:0]  ech = '0, fsel = '0;
   logic        trig, fired;

   int checks = 0, errors = 0;

   // reference state, built from the requirements
   logic [15:0] m_prev = '0;
   logic        m_prev_ok = 1'b0, m_armed = 1'b0, m_fired = 1'b0;

   always #4 clk = ~clk;

   la_trigger_matcher dut (
      .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .fast_mode_i(fmode),
      .state_mask_i(mask), .state_value_i(value), .edge_en_i(en),
      .edge_ch_i(ech), .edge_fall_i(fall), .fast_sel_i(fsel),
      .smp_valid_i(sv), .smp_data_i(sd), .trig_o(trig), .fired_o(fired)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic edge_of(input logic p, input logic c, input logic f);
      return f ? (p & ~c) : (~p & c);
   endfunction

   function automatic logic exp_hit(input logic v, input logic [15:0] d, input logic a);
      logic m, et;
      if (!v || a || !m_armed || m_fired) return 1'b0;
      if (fmode) begin
         m = m_prev_ok && edge_of(m_prev[fsel[2:0]], d[fsel[2:0]], fsel[3]);
      end else begin
         et = 1'b0;
         for (int k = 0; k < 2; k++)
            if (en[k] && m_prev_ok)
               et = et | edge_of(m_prev[ech[k*4 +: 4]], d[ech[k*4 +: 4]], fall[k]);
         m = ((d & mask) == (value & mask)) && ((en == 2'b00) || et);
      end
      return m;
   endfunction

   // one cycle: drive at negedge, clock, check at the following negedge
   task automatic step(input logic v, input logic [15:0] d, input logic a, input string tag);
      logic eh;
      sv = v; sd = d; arm = a;
      eh = exp_hit(v, d, a);
      @(posedge clk);
      if (a) begin
         m_armed = 1'b1; m_fired = 1'b0; m_prev_ok = 1'b0;
      end else begin
         if (eh) m_fired = 1'b1;
         if (v) begin m_prev = d; m_prev_ok = 1'b1; end
      end
      @(negedge clk);
      sv = 1'b0; arm = 1'b0;
      chk({tag, " trig"}, {31'd0, trig}, {31'd0, eh});
      chk({tag, " fired"}, {31'd0, fired}, {31'd0, m_fired});
   endtask

   task automatic cfg(input logic f, input logic [15:0] mk, input logic [15:0] vl,
                      input logic [1:0] e, input logic [7:0] c, input logic [1:0] fl,
                      input logic [7:0] s);
      fmode = f; mask = mk; value = vl; en = e; ech = c; fall = fl; fsel = s;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd20240613));
      repeat (3) @(negedge clk);
      chk("R1 reset trig", {31'd0, trig}, 32'd0);
      chk("R1 reset fired", {31'd0, fired}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: unarmed, all-zero mask would match everything
      cfg(0, 16'h0000, 16'h0000, 2'b00, 8'h00, 2'b00, 8'h00);
      step(1, 16'h1234, 0, "R1");
      step(1, 16'h0000, 0, "R1");

      // R2: masked value compare, value bits outside the mask ignored
      cfg(0, 16'h00F0, 16'hFF5A, 2'b00, 8'h00, 2'b00, 8'h00);
      step(0, 16'h0000, 1, "R2");
      step(1, 16'h0030, 0, "R2");
      step(1, 16'h1259, 0, "R2");
      step(1, 16'h0050, 0, "R7");  // matches again, no second pulse
      step(1, 16'h0050, 0, "R7");

      // R3 rising on channel 5 with detector 0
      cfg(0, 16'h0000, 16'h0000, 2'b01, 8'h05, 2'b00, 8'h00);
      step(0, 16'h0000, 1, "R3");
      step(1, 16'h0000, 0, "R3");
      step(1, 16'h0020, 0, "R3");
      // R5: previous sample holds bit 5 high; falling edge right after arm is ignored
      cfg(0, 16'h0000, 16'h0000, 2'b01, 8'h05, 2'b01, 8'h00);
      step(0, 16'h0000, 1, "R5");
      step(1, 16'h0000, 0, "R5");
      step(1, 16'h0020, 0, "R3");
      step(1, 16'h0000, 0, "R3");

      // R4: detector 0 rising ch2, detector 1 falling ch9, state bit0 = 1
      cfg(0, 16'h0001, 16'h0001, 2'b11, 8'h92, 2'b10, 8'h00);
      step(0, 16'h0000, 1, "R4");
      step(1, 16'h0200, 0, "R4");
      step(1, 16'h0000, 0, "R4");  // edge without state
      step(1, 16'h0201, 0, "R4");  // state without edge
      step(1, 16'h0001, 0, "R4");  // detector 1 plus state
      step(0, 16'h0000, 1, "R4");
      step(1, 16'h0001, 0, "R4");
      step(1, 16'h0005, 0, "R4");  // detector 0 plus state

      // R8: strobe-low cycles are ignored
      cfg(0, 16'h0000, 16'h0000, 2'b01, 8'h03, 2'b00, 8'h00);
      step(0, 16'h0000, 1, "R8");
      step(1, 16'h0000, 0, "R8");
      step(0, 16'h0008, 0, "R8");
      step(1, 16'h0008, 0, "R8");
      // R8: a sample in the arm cycle is discarded
      cfg(0, 16'hFFFF, 16'h1234, 2'b00, 8'h00, 2'b00, 8'h00);
      step(1, 16'h1234, 1, "R8");
      chk("R8 arm cleared fired", {31'd0, fired}, 32'd0);
      step(1, 16'h1234, 0, "R8");

      // R6: fast mode, pin 7 falling; mask, value, detectors ignored
      cfg(1, 16'hFFFF, 16'hABCD, 2'b11, 8'h10, 2'b00, 8'h0F);
      step(0, 16'h0000, 1, "R6");
      step(1, 16'h0080, 0, "R6");
      step(1, 16'h0000, 0, "R6");
      // R6: pin 7 rising, bit 15 toggling has no effect
      cfg(1, 16'h0000, 16'h0000, 2'b00, 8'h00, 2'b00, 8'h07);
      step(0, 16'h0000, 1, "R6");
      step(1, 16'h0000, 0, "R6");
      step(1, 16'h8000, 0, "R6");
      step(1, 16'h8080, 0, "R6");
      // R6: select bits 7:4 ignored, pin 2 rising
      cfg(1, 16'h0000, 16'h0000, 2'b00, 8'h00, 2'b00, 8'hF2);
      step(0, 16'h0000, 1, "R6");
      step(1, 16'h0000, 0, "R6");
      step(1, 16'h0004, 0, "R6");

      // random configurations and sample streams
      d = '0;
      for (int n = 0; n < 3000; n++) begin
         if (n % 40 == 0) begin
            cfg(($urandom % 4) == 0, 16'($urandom & $urandom & $urandom), 16'($urandom),
                2'($urandom), 8'($urandom), 2'($urandom), 8'($urandom));
            step(($urandom % 2) == 1, 16'($urandom), 1, "R8");
         end else begin
            if (($urandom % 3) == 0) d = 16'($urandom);
            else d = d ^ (16'd1 << ($urandom % 16));
            step(($urandom % 5) != 0, d, 0, fmode ? "R6" : "R4");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule